// File: doc/BRIEF.md
# Bit-Serial Steering Adder

This block moves signed 20-bit words between bit-serial links. Every input line carries one word per frame, least significant bit first, with a frame strobe marking bit 0. Each output lane picks up to three of the input lines, gives each pick a sign, and sends out the sum of the picked words. The sum is formed while the bits stream through, so a three-operand sum takes the same 20 cycles as a plain copy.

A command word is applied at every frame strobe. For each lane it holds one slot per operand, and each slot carries an enable, a negate flag and an input select. Subtraction is done by inverting the operand bits and putting the matching +1 into the lane carry at bit 0. The outputs run with a delayed frame strobe, so a lane can drive an input of another unit of the same kind. Words follow each other with no gap, because the next word goes in while the previous one is still coming out.

Top module: `serial_steer_adder`

## Requirements
- R1: While reset is held, and on release, `ser_o`, `frame_o` and `ovf_o` are all zero.
- R2: Output bit n of a word appears on `ser_o` one clock after input bit n is presented. `frame_o` is `frame_i` delayed by one clock, so it marks output bit 0.
- R3: A lane with one enabled, non-negated slot sends out an exact copy of the selected input word.
- R4: A lane sends out the sum, modulo 2^20, of all its enabled slot operands. Two or three operands may be used, with any mix of signs.
- R5: In the 6-bit slot, bit 5 is the enable, bit 4 is the negate flag and bits 3:0 are the input select. A negated operand adds minus the word. A disabled slot adds zero, whatever its other bits hold.
- R6: A select code of 13, 14 or 15 reads as an all-zero word.
- R7: `cmd_i` is sampled only in the cycle where `frame_i` is high. Changes to it during the other 19 bits of a word have no effect on that word.
- R8: The lane carry restarts at each frame strobe. Words sent back to back give results that do not depend on one another.
- R9: `ovf_o[o]` is set when the exact signed sum of lane o falls outside -2^19..2^19-1. It stays set until reset, and it does not affect the other lanes.
- R10: Lanes work independently. Several lanes may select the same input in the same word.
- R11: `cmd_i` layout: the slot for lane o, operand k sits at bits [(o*3+k)*6 +: 6].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | High while the inputs carry bit 0 of a word |
| ser_i | input | 13 | Serial input lines, LSB first |
| cmd_i | input | 54 | Per-lane operand slots, sampled at frame_i |
| ser_o | output | 3 | Serial lane outputs |
| frame_o | output | 1 | Frame strobe aligned to ser_o |
| ovf_o | output | 3 | Sticky signed-overflow flag per lane |

## Verification
The main table streams words back to back through three kinds of lane. Lane 0 runs two- and three-operand sums with every mix of signs, carry chains that reach the top bit, all slots disabled, and all slots negated. Lane 1 is a plain copy, so it separates routing faults from adder faults. Lane 2 adds an out-of-range select to a negated operand, which exposes any fault in the zero-fill or in the carry injection. Directed runs then change the command during a word, route one input to all lanes at once, and push single lanes past positive and negative full scale, which shows whether the overflow flag is sticky and stays in its own lane.

// File: rtl/serial_steer_pkg.sv
package serial_steer_pkg;
   localparam int DEF_NUM_IN  = 13;
   localparam int DEF_NUM_OUT = 3;
   localparam int DEF_WORD_W  = 20;
   localparam int DEF_NUM_OPS = 3;

   // slot = {enable, negate, select}
   function automatic int slot_width(input int sel_w);
      return sel_w + 2;
   endfunction
endpackage

// File: rtl/ssa_bit_pos.sv
module ssa_bit_pos #(
   parameter int WORD_W = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_i,
   output logic msb_o
);
   localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   logic [BW-1:0] cnt_q;
   logic [BW-1:0] pos;

   always_comb begin
      pos   = frame_i ? '0 : cnt_q;
      msb_o = (pos == BW'(WORD_W - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (msb_o)  cnt_q <= '0;
      else             cnt_q <= pos + BW'(1);
   end
endmodule

// File: rtl/ssa_lane.sv
module ssa_lane #(
   parameter int NUM_IN  = 13,
   parameter int NUM_OPS = 3,
   parameter int SEL_W   = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              frame_i,
   input  logic                              msb_i,
   input  logic [NUM_IN-1:0]                 ser_i,
   input  logic [NUM_OPS*(SEL_W+2)-1:0]      slots_i,
   output logic                              ser_o,
   output logic                              ovf_o
);
   localparam int SLOT_W = SEL_W + 2;
   localparam int PAD_N  = 1 << SEL_W;
   localparam int CW     = $clog2(NUM_OPS + 1);
   localparam int SW     = $clog2(2 * NUM_OPS + 2);

   logic [PAD_N-1:0]   pad;
   logic [NUM_OPS-1:0] opb;
   logic [NUM_OPS-1:0] inj;
   logic [SW-1:0]      nb, ninj, total, cin_w;
   logic [CW-1:0]      carry_q, cin;
   logic               ovf_hit;

   always_comb begin
      pad = '0;
      pad[NUM_IN-1:0] = ser_i;
      for (int k = 0; k < NUM_OPS; k++) begin
         logic [SLOT_W-1:0] s;
         s      = slots_i[k*SLOT_W +: SLOT_W];
         opb[k] = s[SLOT_W-1] & (pad[s[SEL_W-1:0]] ^ s[SLOT_W-2]);
         inj[k] = s[SLOT_W-1] & s[SLOT_W-2];
      end
      nb   = '0;
      ninj = '0;
      for (int k = 0; k < NUM_OPS; k++) begin
         nb   = nb + SW'(opb[k]);
         ninj = ninj + SW'(inj[k]);
      end
      cin     = frame_i ? CW'(ninj) : carry_q;
      cin_w   = SW'(cin);
      total   = nb + cin_w;
      // top bit: exact value fits only if carry-in minus set bits is 0 or -1
      ovf_hit = msb_i && (cin_w != nb) && ((cin_w + SW'(1)) != nb);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q <= '0;
         ser_o   <= 1'b0;
         ovf_o   <= 1'b0;
      end else begin
         carry_q <= CW'(total >> 1);
         ser_o   <= total[0];
         if (ovf_hit) ovf_o <= 1'b1;
      end
   end
endmodule

// File: rtl/serial_steer_adder.sv
module serial_steer_adder
   import serial_steer_pkg::*;
#(
   parameter int NUM_IN  = DEF_NUM_IN,
   parameter int NUM_OUT = DEF_NUM_OUT,
   parameter int WORD_W  = DEF_WORD_W,
   parameter int NUM_OPS = DEF_NUM_OPS,
   localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
   localparam int SLOT_W = SEL_W + 2,
   localparam int LANE_W = NUM_OPS * SLOT_W,
   localparam int CMD_W  = NUM_OUT * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_i,
   input  logic [NUM_IN-1:0]  ser_i,
   input  logic [CMD_W-1:0]   cmd_i,
   output logic [NUM_OUT-1:0] ser_o,
   output logic               frame_o,
   output logic [NUM_OUT-1:0] ovf_o
);
   if (NUM_OPS < 1) begin : g_bad_ops
      $error("NUM_OPS must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (NUM_OUT < 1 || NUM_IN < 1) begin : g_bad_ports
      $error("NUM_IN and NUM_OUT must be at least 1");
   end

   logic [CMD_W-1:0] cmd_lat;
   logic [CMD_W-1:0] cmd_eff;
   logic             msb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_lat <= '0;
         frame_o <= 1'b0;
      end else begin
         if (frame_i) cmd_lat <= cmd_i;
         frame_o <= frame_i;
      end
   end

   // bit 0 uses the fresh command, the rest of the word the latched copy
   assign cmd_eff = frame_i ? cmd_i : cmd_lat;

   ssa_bit_pos #(.WORD_W(WORD_W)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_i (frame_i),
      .msb_o   (msb)
   );

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_lane
      ssa_lane #(
         .NUM_IN  (NUM_IN),
         .NUM_OPS (NUM_OPS),
         .SEL_W   (SEL_W)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .frame_i (frame_i),
         .msb_i   (msb),
         .ser_i   (ser_i),
         .slots_i (cmd_eff[o*LANE_W +: LANE_W]),
         .ser_o   (ser_o[o]),
         .ovf_o   (ovf_o[o])
      );
   end
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
   parameter int NUM_OUT = 3,
   parameter int CMD_W   = 54
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_i,
   input logic               frame_o,
   input logic [NUM_OUT-1:0] ovf_o,
   input logic [CMD_W-1:0]   cmd_lat
);
   p_frame_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_i |=> frame_o);

   p_frame_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_i |=> !frame_o);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o != '0) |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

   p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_i |=> $stable(cmd_lat));
endmodule

bind serial_steer_adder ssa_checker #(.NUM_OUT(NUM_OUT), .CMD_W(CMD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .frame_i (frame_i),
   .frame_o (frame_o),
   .ovf_o   (ovf_o),
   .cmd_lat (cmd_lat)
);

// File: tb/sim_serial_steer_adder.sv
module sim_serial_steer_adder;
   localparam int PERIOD = 10;
   localparam int W  = 20;
   localparam int NI = 13;
   localparam int NO = 3;
   localparam int CW = 54;

   typedef logic [W-1:0] word_t;
   typedef struct packed {
      logic [W-1:0] a, b, c;
      logic [2:0]   en, ng;
      logic [W-1:0] exp;
   } vec_t;

   // lane0 ops: a on input 3, b on input 8, c on input 12
   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{20'h00005, 20'h00003, 20'h00000, 3'b011, 3'b000, 20'h00008},
      '{20'h00005, 20'h00003, 20'h00000, 3'b011, 3'b010, 20'h00002},
      '{20'h00003, 20'h00005, 20'h00000, 3'b011, 3'b010, 20'hFFFFE},
      '{20'h00010, 20'h00020, 20'h00030, 3'b111, 3'b000, 20'h00060},
      '{20'h00100, 20'h00001, 20'h00002, 3'b111, 3'b110, 20'h000FD},
      '{20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 3'b111, 3'b000, 20'hFFFFD},
      '{20'h12345, 20'h00000, 20'h00000, 3'b001, 3'b000, 20'h12345},
      '{20'h00007, 20'h00009, 20'h0000B, 3'b000, 3'b111, 20'h00000},
      '{20'h00001, 20'h00002, 20'h00003, 3'b111, 3'b111, 20'hFFFFA},
      '{20'h00000, 20'h00000, 20'h7FFFF, 3'b100, 3'b100, 20'h80001}
   };

   logic clk = 0;
   logic rst_n;
   logic frame_i;
   logic [NI-1:0] ser_i;
   logic [CW-1:0] cmd_i;
   logic [NO-1:0] ser_o, ovf_o;
   logic frame_o;

   int n_chk = 0, n_fail = 0;
   word_t win [NI];
   logic [CW-1:0] cmd_cur;
   word_t res [NO][64];
   word_t cap [NO];
   int nres = 0;
   int mpos = 100;

   serial_steer_adder u0 (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .ser_i(ser_i),
      .cmd_i(cmd_i), .ser_o(ser_o), .frame_o(frame_o), .ovf_o(ovf_o));

   always #(PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (frame_o) mpos = 0; else mpos++;
      if (mpos < W) begin
         for (int o = 0; o < NO; o++) cap[o][mpos] = ser_o[o];
         if (mpos == W-1) begin
            for (int o = 0; o < NO; o++) res[o][nres] = cap[o];
            nres++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] slot(input bit en, input bit ng, input int sel);
      return {en, ng, 4'(sel)};
   endfunction

   function automatic void put(inout logic [CW-1:0] c, input int o, input int k, input logic [5:0] s);
      c[(o*3+k)*6 +: 6] = s;
   endfunction

   function automatic void model(input int o, output word_t r, output bit ov);
      longint v = 0;
      for (int k = 0; k < 3; k++) begin
         logic [5:0] s;
         longint x;
         s = cmd_cur[(o*3+k)*6 +: 6];
         x = (s[3:0] < NI) ? longint'($signed(win[s[3:0]])) : 0;
         if (s[5]) v += s[4] ? -x : x;
      end
      r  = word_t'(v);
      ov = (v > 524287) || (v < -524288);
   endfunction

   task automatic send_word(input bit scramble, input bit chk_lat);
      for (int i = 0; i < W; i++) begin
         @(negedge clk);
         if (chk_lat && i == 1) begin
            chk(frame_o == 1'b1, "R2 frame_o", frame_o, 1);
            chk(ser_o[1] == win[3][0], "R2 bit0 latency", ser_o[1], win[3][0]);
         end
         frame_i = (i == 0);
         for (int j = 0; j < NI; j++) ser_i[j] = win[j][i];
         cmd_i = (scramble && i > 0) ? ~cmd_cur : cmd_cur;
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      frame_i = 0; ser_i = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_in();
      for (int j = 0; j < NI; j++) win[j] = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; frame_i = 0; ser_i = '0; cmd_i = '0;
      repeat (3) @(negedge clk);
      chk(ser_o == '0 && frame_o == 0 && ovf_o == '0, "R1 reset outputs",
          {ser_o, frame_o, ovf_o}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(ovf_o == '0 && frame_o == 0, "R1 after release", {frame_o, ovf_o}, 0);
   endtask

   initial begin
      #(PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      word_t r, exp0 [NV], exp1 [NV], exp2 [NV];
      bit ov;
      int base;
      rst_n = 0; frame_i = 0; ser_i = '0; cmd_i = '0;
      clear_in();
      do_reset();

      // table: back-to-back words (R3 R4 R5 R6 R8 R11)
      base = nres;
      for (int v = 0; v < NV; v++) begin
         clear_in();
         win[3] = TBL[v].a; win[8] = TBL[v].b; win[12] = TBL[v].c;
         cmd_cur = '0;
         put(cmd_cur, 0, 0, slot(TBL[v].en[0], TBL[v].ng[0], 3));
         put(cmd_cur, 0, 1, slot(TBL[v].en[1], TBL[v].ng[1], 8));
         put(cmd_cur, 0, 2, slot(TBL[v].en[2], TBL[v].ng[2], 12));
         put(cmd_cur, 1, 0, slot(1, 0, 3));
         put(cmd_cur, 2, 0, slot(1, 0, 14));
         put(cmd_cur, 2, 1, slot(1, 1, 8));
         exp0[v] = TBL[v].exp;
         exp1[v] = TBL[v].a;
         model(2, r, ov); exp2[v] = r;
         send_word(0, v == 0);
      end
      go_idle();
      for (int v = 0; v < NV; v++) begin
         chk(res[0][base+v] == exp0[v], "R4 R5 R8 lane0 sum", res[0][base+v], exp0[v]);
         chk(res[1][base+v] == exp1[v], "R3 lane1 copy", res[1][base+v], exp1[v]);
         chk(res[2][base+v] == exp2[v], "R6 R5 lane2 zero-select minus b", res[2][base+v], exp2[v]);
      end
      chk(ovf_o == '0, "R9 no false overflow", ovf_o, 0);

      // R7: command changes mid-word are ignored
      base = nres;
      clear_in();
      win[3] = 20'h00321; win[8] = 20'h00123;
      cmd_cur = '0;
      put(cmd_cur, 0, 0, slot(1, 0, 3));
      put(cmd_cur, 0, 1, slot(1, 1, 8));
      send_word(1, 0);
      go_idle();
      chk(res[0][base] == 20'h001FE, "R7 cmd held over word", res[0][base], 20'h001FE);

      // R10: all lanes read the same input
      base = nres;
      clear_in();
      win[5] = 20'hA5A5A;
      cmd_cur = '0;
      for (int o = 0; o < NO; o++) put(cmd_cur, o, 0, slot(1, 0, 5));
      put(cmd_cur, 2, 1, slot(1, 0, 5));
      send_word(0, 0);
      go_idle();
      chk(res[0][base] == 20'hA5A5A, "R10 lane0 shared input", res[0][base], 20'hA5A5A);
      chk(res[1][base] == 20'hA5A5A, "R10 lane1 shared input", res[1][base], 20'hA5A5A);
      chk(res[2][base] == 20'h4B4B4, "R10 lane2 doubled wraps", res[2][base], 20'h4B4B4);
      chk(ovf_o == 3'b100, "R9 doubled negative overflows lane2 only", ovf_o, 3'b100);

      // R9: positive overflow on lane 0 wraps, flag sticky, lanes separate
      do_reset();
      base = nres;
      clear_in();
      win[0] = 20'h7FFFF; win[1] = 20'h00001;
      cmd_cur = '0;
      put(cmd_cur, 0, 0, slot(1, 0, 0));
      put(cmd_cur, 0, 1, slot(1, 0, 1));
      put(cmd_cur, 1, 0, slot(1, 0, 0));
      send_word(0, 0);
      go_idle();
      chk(res[0][base] == 20'h80000, "R9 wrap value", res[0][base], 20'h80000);
      chk(ovf_o == 3'b001, "R9 overflow lane0 only", ovf_o, 3'b001);
      base = nres;
      win[1] = 20'h00000;
      send_word(0, 0);
      go_idle();
      chk(res[0][base] == 20'h7FFFF, "R8 next word clean", res[0][base], 20'h7FFFF);
      chk(ovf_o == 3'b001, "R9 flag sticky", ovf_o, 3'b001);

      // R9 and R5: negating the most negative word overflows
      do_reset();
      base = nres;
      clear_in();
      win[9] = 20'h80000;
      cmd_cur = '0;
      put(cmd_cur, 2, 2, slot(1, 1, 9));
      put(cmd_cur, 1, 0, slot(1, 0, 9));
      send_word(0, 0);
      go_idle();
      chk(res[2][base] == 20'h80000, "R5 negate min wraps", res[2][base], 20'h80000);
      chk(ovf_o == 3'b100, "R9 negate min overflow lane2", ovf_o, 3'b100);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule